// File: doc/BRIEF.md
# Dual-Processor Doorbell Interrupt Unit

This unit lets two processors ring each other through level interrupts. Each processor owns a four-bit pending word. Any bus master can add bits to that word through a raise port and remove bits through a drop port. A view port returns the current value. The interrupt line of a processor stays high for as long as its pending word holds any set bit. The owning processor clears the bits it has serviced, and that lowers the line.

The unit answers single 32-bit reads and writes on a simple APB-style register bus inside a 4 KB window, with no wait states and no error response. A write commits at the clock edge that ends the access phase (select and enable both high). A read returns data combinationally during the access. The top twelve words of the window hold a fixed table of identification bytes, each read back zero-extended.

Processor p owns offsets 0x10*p + 0x0 (view), 0x10*p + 0x4 (raise) and 0x10*p + 0x8 (drop).

Top module: `doorbell_unit`

## Requirements
- R1: Synchronous active-low reset clears both pending words. Both interrupt outputs are then low, and both view ports read zero.
- R2: A write to a raise port (0x04 for processor 0, 0x14 for processor 1) ORs write-data bits [3:0] into that processor's pending word.
- R3: A write to a drop port (0x08 for processor 0, 0x18 for processor 1) replaces that processor's pending word with pending AND NOT write-data[3:0].
- R4: Write-data bits [31:4] have no effect on any pending word.
- R5: Each interrupt output (doorbell_irq[p] for processor p) is high exactly when that pending word is nonzero. It changes at the clock edge that commits the write, and is unchanged during the access phase before that edge.
- R6: A read of a view port (0x00, 0x10) returns the pending word in bits [3:0], with bits [31:4] zero.
- R7: Reads of raise and drop ports return zero.
- R8: Reads of word offsets 0xFD0 up to 0xFFC, in steps of 4, return 0x04, 0x00, 0x00, 0x00, 0x56, 0xB8, 0x0B, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in that order, zero-extended to 32 bits.
- R9: Writes to view ports, identification words, unmapped offsets or addresses with bits [1:0] nonzero change no state.
- R10: Reads of unmapped offsets, including any address with bits [1:0] nonzero, return zero.
- R11: A write to one processor's ports never changes the other processor's pending word.
- R12: A setup phase (select high, enable low) without a following access phase changes no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Peripheral select |
| bus_en | input | 1 | Access-phase enable |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address inside the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, zero when no read is active |
| doorbell_irq | output | 2 | Level interrupt per processor, bit p for processor p |

## Verification
The bench attacks the places where raise and drop are easy to confuse. These are a drop that clears only some of the bits, a raise of bits already set, and write data whose upper bits are all ones. A design that ignored the mask would corrupt the word, and one that treated drop as a plain store would lose bits. Writes to view ports, to identification words, to holes and to misaligned addresses are each followed by a read and an interrupt check, which catches a decoder that aliases them onto a live port. A setup phase with no access phase and a reset in the middle of a run probe the write strobe and the reset path. The full identification table is read in order to catch swapped or shifted entries.

// File: rtl/doorbell_pkg.sv
// Shared definitions for the doorbell unit: slot encoding inside a
// processor bank and the fixed identification byte table.
// Assumes identification words sit at the very top of the address window.
package doorbell_pkg;

    localparam int ID_COUNT = 12;

    // Word slot inside one 16-byte processor bank (address bits [3:2]).
    typedef enum logic [1:0] {
        SLOT_VIEW  = 2'd0,
        SLOT_RAISE = 2'd1,
        SLOT_DROP  = 2'd2,
        SLOT_NONE  = 2'd3
    } slot_e;

    // Identification byte by table position (0 = lowest address).
    function automatic logic [7:0] id_byte(input logic [3:0] idx);
        case (idx)
            4'd0:    id_byte = 8'h04;
            4'd4:    id_byte = 8'h56;
            4'd5:    id_byte = 8'hB8;
            4'd6:    id_byte = 8'h0B;
            4'd8:    id_byte = 8'h0D;
            4'd9:    id_byte = 8'hF0;
            4'd10:   id_byte = 8'h05;
            4'd11:   id_byte = 8'hB1;
            default: id_byte = 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/doorbell_addr_dec.sv
// Address decoder for the doorbell unit.
// Splits the byte address into a processor bank (bits above 3) and a slot
// (bits [3:2]), and flags the identification block at the window top.
// Assumes: only word-aligned addresses hit anything; banks 0..NUM_PROC-1.
module doorbell_addr_dec
    import doorbell_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int NUM_PROC = 2
) (
    input  logic [ADDR_W-1:0]   addr,
    output logic [NUM_PROC-1:0] hit_view,
    output logic [NUM_PROC-1:0] hit_raise,
    output logic [NUM_PROC-1:0] hit_drop,
    output logic                hit_id,
    output logic [3:0]          id_idx
);
    localparam int WORD_W       = ADDR_W - 2;
    localparam int BANK_W       = ADDR_W - 4;
    localparam int ID_BASE_WORD = (1 << WORD_W) - ID_COUNT;

    logic              aligned;
    logic [WORD_W-1:0] word;
    logic [BANK_W-1:0] bank;
    slot_e             slot;
    logic [WORD_W-1:0] id_off;

    assign aligned = (addr[1:0] == 2'b00);
    assign word    = addr[ADDR_W-1:2];
    assign bank    = addr[ADDR_W-1:4];
    assign slot    = slot_e'(addr[3:2]);

    // Per-processor slot hits, one set of comparators per bank.
    for (genvar g = 0; g < NUM_PROC; g++) begin : g_bank
        logic in_bank;
        assign in_bank      = aligned && (bank == BANK_W'(g));
        assign hit_view[g]  = in_bank && (slot == SLOT_VIEW);
        assign hit_raise[g] = in_bank && (slot == SLOT_RAISE);
        assign hit_drop[g]  = in_bank && (slot == SLOT_DROP);
    end

    // Identification block hit and table position.
    assign id_off = word - WORD_W'(ID_BASE_WORD);
    assign hit_id = aligned && (word >= WORD_W'(ID_BASE_WORD));
    assign id_idx = id_off[3:0];

endmodule

// File: rtl/doorbell_pend_reg.sv
// One processor's pending doorbell word with raise/drop update and a
// level interrupt taken straight from the stored word.
// Assumes raise and drop strobes are never high together (distinct addresses).
module doorbell_pend_reg #(
    parameter int LIVE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              raise_we,
    input  logic              drop_we,
    input  logic [LIVE_W-1:0] wmask,
    output logic [LIVE_W-1:0] pend,
    output logic              irq
);
    // Pending word: OR in on raise, mask out on drop, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= '0;
        end else if (raise_we) begin
            pend <= pend | wmask;
        end else if (drop_we) begin
            pend <= pend & ~wmask;
        end
    end

    // Interrupt level follows the stored word.
    assign irq = |pend;

endmodule

// File: rtl/doorbell_id_rom.sv
// Identification word source: returns the table byte zero-extended to the
// bus width when the decoder flags an identification hit, zero otherwise.
// Assumes idx is within 0..ID_COUNT-1 whenever hit is high.
module doorbell_id_rom
    import doorbell_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              hit,
    input  logic [3:0]        idx,
    output logic [DATA_W-1:0] data
);
    // Zero-extend the selected byte.
    assign data = hit ? DATA_W'(id_byte(idx)) : '0;

endmodule

// File: rtl/doorbell_unit.sv
// Dual-processor doorbell interrupt unit, top level.
// Writes commit on the access-phase edge (sel & en & wr); reads are
// combinational with zero wait states. Pending words are LIVE_W bits wide.
// Assumes single full-width accesses; no wait or error response exists.
module doorbell_unit #(
    parameter int ADDR_W   = 12,
    parameter int DATA_W   = 32,
    parameter int LIVE_W   = 4,
    parameter int NUM_PROC = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_sel,
    input  logic                bus_en,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic [NUM_PROC-1:0] doorbell_irq
);
    logic [NUM_PROC-1:0] hit_view;
    logic [NUM_PROC-1:0] hit_raise;
    logic [NUM_PROC-1:0] hit_drop;
    logic                hit_id;
    logic [3:0]          id_idx;
    logic [DATA_W-1:0]   id_data;
    logic                wr_fire;
    logic                rd_act;
    logic [LIVE_W-1:0]   wmask;
    logic [LIVE_W-1:0]   pend [NUM_PROC];
    logic [DATA_W-1:0]   rd_mux;
    logic                unused_wdata_hi;

    assign wr_fire         = bus_sel && bus_en && bus_wr;
    assign rd_act          = bus_sel && !bus_wr;
    assign wmask           = bus_wdata[LIVE_W-1:0];
    assign unused_wdata_hi = ^bus_wdata[DATA_W-1:LIVE_W];

    doorbell_addr_dec #(
        .ADDR_W   (ADDR_W),
        .NUM_PROC (NUM_PROC)
    ) u_dec (
        .addr      (bus_addr),
        .hit_view  (hit_view),
        .hit_raise (hit_raise),
        .hit_drop  (hit_drop),
        .hit_id    (hit_id),
        .id_idx    (id_idx)
    );

    doorbell_id_rom #(
        .DATA_W (DATA_W)
    ) u_id (
        .hit  (hit_id),
        .idx  (id_idx),
        .data (id_data)
    );

    // One pending register per processor.
    for (genvar g = 0; g < NUM_PROC; g++) begin : g_proc
        doorbell_pend_reg #(
            .LIVE_W (LIVE_W)
        ) u_pend (
            .clk      (clk),
            .rst_n    (rst_n),
            .raise_we (wr_fire && hit_raise[g]),
            .drop_we  (wr_fire && hit_drop[g]),
            .wmask    (wmask),
            .pend     (pend[g]),
            .irq      (doorbell_irq[g])
        );
    end

    // Read mux: identification data OR the selected view port.
    always_comb begin
        rd_mux = id_data;
        for (int p = 0; p < NUM_PROC; p++) begin
            if (hit_view[p]) begin
                rd_mux = rd_mux | DATA_W'(pend[p]);
            end
        end
    end

    // Drive read data only while a read is selected.
    assign bus_rdata = rd_act ? rd_mux : '0;

endmodule

// File: rtl/doorbell_unit_chk.sv
// Protocol checker for doorbell_unit, attached by bind. Observes only the
// top-level ports and relates them across clock edges.
// Assumes reset is asserted from time zero by the environment.
module doorbell_unit_chk #(
    parameter int ADDR_W   = 12,
    parameter int DATA_W   = 32,
    parameter int LIVE_W   = 4,
    parameter int NUM_PROC = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_sel,
    input logic                bus_en,
    input logic                bus_wr,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [DATA_W-1:0]   bus_wdata,
    input logic [DATA_W-1:0]   bus_rdata,
    input logic [NUM_PROC-1:0] doorbell_irq
);
    logic wr_fire;
    logic rd_act;
    logic unused_chk_hi;

    assign wr_fire       = bus_sel && bus_en && bus_wr;
    assign rd_act        = bus_sel && !bus_wr;
    assign unused_chk_hi = ^bus_wdata[DATA_W-1:LIVE_W];

    // Quiet cycles leave all interrupt lines alone (R9).
    assert_idle_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_fire |=> $stable(doorbell_irq));

    // A setup phase alone changes nothing (R12).
    assert_setup_only_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_en) |=> $stable(doorbell_irq));

    // Misaligned reads return zero (R10).
    assert_misaligned_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_act && bus_addr[1:0] != 2'b00) |-> (bus_rdata == '0));

    for (genvar g = 0; g < NUM_PROC; g++) begin : g_chk
        localparam logic [ADDR_W-1:0] VIEW_A  = ADDR_W'(g * 16);
        localparam logic [ADDR_W-1:0] RAISE_A = ADDR_W'(g * 16 + 4);
        localparam logic [ADDR_W-1:0] DROP_A  = ADDR_W'(g * 16 + 8);

        // Raising any live bit asserts the line one edge later (R2).
        assert_raise_irq_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_fire && bus_addr == RAISE_A && bus_wdata[LIVE_W-1:0] != '0)
            |=> doorbell_irq[g]);

        // Dropping every live bit deasserts the line (R3).
        assert_drop_all_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_fire && bus_addr == DROP_A && (&bus_wdata[LIVE_W-1:0]))
            |=> !doorbell_irq[g]);

        // Write-only ports read back zero (R7).
        assert_port_read_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_act && (bus_addr == RAISE_A || bus_addr == DROP_A))
            |-> (bus_rdata == '0));

        // View reads carry nothing above the live bits (R6).
        assert_view_upper_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_act && bus_addr == VIEW_A)
            |-> (bus_rdata[DATA_W-1:LIVE_W] == '0));

        // Writes into another bank leave this line alone (R11).
        assert_other_untouched_R11: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_fire && bus_addr[ADDR_W-1:4] != (ADDR_W-4)'(g))
            |=> $stable(doorbell_irq[g]));
    end

endmodule

bind doorbell_unit doorbell_unit_chk #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .LIVE_W   (LIVE_W),
    .NUM_PROC (NUM_PROC)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_sel      (bus_sel),
    .bus_en       (bus_en),
    .bus_wr       (bus_wr),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .doorbell_irq (doorbell_irq)
);

// File: tb/tb_doorbell_unit.sv
module tb_doorbell_unit;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic        is_wr;
        logic [3:0]  req;
        logic [11:0] addr;
        logic [31:0] data;     // write data, or expected read data
        logic [1:0]  exp_irq;  // interrupt lines expected afterwards
    } vec_t;

    localparam int NV = 32;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 4'd2,  12'h004, 32'h0000_0005, 2'b01}, // R2 raise p0
        '{1'b0, 4'd6,  12'h000, 32'h0000_0005, 2'b01}, // R6 view p0
        '{1'b1, 4'd4,  12'h014, 32'hFFFF_FFF2, 2'b11}, // R4 upper bits masked
        '{1'b0, 4'd6,  12'h010, 32'h0000_0002, 2'b11}, // R6 view p1
        '{1'b1, 4'd2,  12'h004, 32'h0000_0002, 2'b11}, // R2 OR more bits
        '{1'b0, 4'd2,  12'h000, 32'h0000_0007, 2'b11},
        '{1'b1, 4'd3,  12'h008, 32'h0000_0001, 2'b11}, // R3 partial drop
        '{1'b0, 4'd3,  12'h000, 32'h0000_0006, 2'b11},
        '{1'b0, 4'd7,  12'h004, 32'h0000_0000, 2'b11}, // R7
        '{1'b0, 4'd7,  12'h008, 32'h0000_0000, 2'b11},
        '{1'b0, 4'd7,  12'h018, 32'h0000_0000, 2'b11},
        '{1'b1, 4'd9,  12'h000, 32'h0000_000F, 2'b11}, // R9 view write
        '{1'b0, 4'd9,  12'h000, 32'h0000_0006, 2'b11},
        '{1'b1, 4'd3,  12'h018, 32'h0000_000F, 2'b01}, // R3 drop all p1
        '{1'b0, 4'd11, 12'h000, 32'h0000_0006, 2'b01}, // R11 p0 kept
        '{1'b1, 4'd4,  12'h008, 32'hFFFF_FFF0, 2'b01}, // R4 no live bits
        '{1'b0, 4'd4,  12'h000, 32'h0000_0006, 2'b01},
        '{1'b1, 4'd9,  12'h FD0, 32'h0000_00FF, 2'b01}, // R9 id write
        '{1'b0, 4'd8,  12'hFD0, 32'h0000_0004, 2'b01},
        '{1'b1, 4'd9,  12'h020, 32'h0000_000F, 2'b01}, // R9 hole write
        '{1'b0, 4'd10, 12'h020, 32'h0000_0000, 2'b01}, // R10
        '{1'b0, 4'd10, 12'h00C, 32'h0000_0000, 2'b01},
        '{1'b0, 4'd10, 12'h01C, 32'h0000_0000, 2'b01},
        '{1'b1, 4'd9,  12'h010, 32'h0000_000F, 2'b01},
        '{1'b0, 4'd9,  12'h010, 32'h0000_0000, 2'b01},
        '{1'b1, 4'd11, 12'h014, 32'h0000_0008, 2'b11}, // R11
        '{1'b1, 4'd2,  12'h004, 32'h0000_0000, 2'b11},
        '{1'b1, 4'd3,  12'h008, 32'h0000_0006, 2'b10},
        '{1'b0, 4'd3,  12'h000, 32'h0000_0000, 2'b10},
        '{1'b0, 4'd11, 12'h010, 32'h0000_0008, 2'b10},
        '{1'b1, 4'd3,  12'h018, 32'h0000_0008, 2'b00},
        '{1'b0, 4'd5,  12'h010, 32'h0000_0000, 2'b00}  // R5
    };

    localparam logic [7:0] ID_EXP [12] = '{
        8'h04, 8'h00, 8'h00, 8'h00, 8'h56, 8'hB8,
        8'h0B, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1
    };

    logic        clk;
    logic        rst_n;
    logic        bus_sel;
    logic        bus_en;
    logic        bus_wr;
    logic [11:0] bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic [1:0]  doorbell_irq;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    doorbell_unit dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_sel      (bus_sel),
        .bus_en       (bus_en),
        .bus_wr       (bus_wr),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .doorbell_irq (doorbell_irq)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_en = 1'b0; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b1;
        @(negedge clk);
        bus_sel = 1'b0; bus_en = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_en = 1'b0; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_en = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0; bus_en = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(CLK_PERIOD * 100000);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] rd;
        rst_n = 1'b0; bus_sel = 1'b0; bus_en = 1'b0; bus_wr = 1'b0;
        bus_addr = '0; bus_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1 irq after reset", {30'b0, doorbell_irq}, 32'h0);
        bus_read(12'h000, rd); check("R1 view p0", rd, 32'h0);
        bus_read(12'h010, rd); check("R1 view p1", rd, 32'h0);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            if (VEC[i].is_wr) begin
                bus_write(VEC[i].addr, VEC[i].data);
            end else begin
                bus_read(VEC[i].addr, rd);
                check($sformatf("R%0d row %0d rdata", VEC[i].req, i), rd, VEC[i].data);
            end
            check($sformatf("R5 row %0d irq", i), {30'b0, doorbell_irq}, {30'b0, VEC[i].exp_irq});
        end

        // R8 full identification table in order
        for (int k = 0; k < 12; k++) begin
            bus_read(12'hFD0 + 12'(4 * k), rd);
            check($sformatf("R8 id word %0d", k), rd, {24'b0, ID_EXP[k]});
        end

        // R10 other unmapped and misaligned reads
        bus_read(12'h800, rd); check("R10 hole 0x800", rd, 32'h0);
        bus_read(12'hFCC, rd); check("R10 below id 0xFCC", rd, 32'h0);
        bus_read(12'h001, rd); check("R10 misaligned 0x001", rd, 32'h0);

        // R12 setup phase without access phase
        @(negedge clk);
        bus_sel = 1'b1; bus_en = 1'b0; bus_wr = 1'b1; bus_addr = 12'h004; bus_wdata = 32'hF;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        @(negedge clk);
        check("R12 irq after setup only", {30'b0, doorbell_irq}, 32'h0);
        bus_read(12'h000, rd); check("R12 view after setup only", rd, 32'h0);

        // R9 misaligned write onto a raise port address
        bus_write(12'h005, 32'hF);
        check("R9 irq after misaligned write", {30'b0, doorbell_irq}, 32'h0);
        bus_read(12'h000, rd); check("R9 view after misaligned write", rd, 32'h0);

        // R5 timing: line unchanged during access phase, set after its edge
        @(negedge clk);
        bus_sel = 1'b1; bus_en = 1'b0; bus_wr = 1'b1; bus_addr = 12'h014; bus_wdata = 32'h1;
        @(negedge clk);
        bus_en = 1'b1;
        #1 check("R5 irq before commit edge", {30'b0, doorbell_irq}, 32'h0);
        @(negedge clk);
        bus_sel = 1'b0; bus_en = 1'b0; bus_wr = 1'b0;
        check("R5 irq after commit edge", {30'b0, doorbell_irq}, 32'h2);

        // R1 reset in the middle of a run
        bus_write(12'h004, 32'hF);
        check("R1 irq before mid reset", {30'b0, doorbell_irq}, 32'h3);
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        check("R1 irq after mid reset", {30'b0, doorbell_irq}, 32'h0);
        bus_read(12'h000, rd); check("R1 view p0 after mid reset", rd, 32'h0);
        bus_read(12'h010, rd); check("R1 view p1 after mid reset", rd, 32'h0);

        finish_run();
    end

endmodule